// File: doc/BRIEF.md
# Two-Stage-Reload Watchdog Timer

This block supervises the firmware of a small microcontroller. A machine-cycle enable, one clock wide and derived from the oscillator, advances a prescaler. Each time the prescaler wraps, an up-counter advances. When the counter steps past its all-ones value, the block issues a one-clock internal system reset. It also drives an external reset pulse that lasts a fixed number of machine cycles.

Firmware must reload the counter often enough to stay clear of overflow. A reload takes two steps. The first write sets an arm flag in the control register. The second write, to the counter, loads the value. An accepted counter write drops the arm flag, so a stray single write can never feed the watchdog.

The watchdog runs while the active-low enable pin is low, and no register write can stop it in that state. While it runs, the power-down request bit in the control register is forced to zero. When the enable pin is high, the prescaler and counter stay at zero and no reset is produced.

Top module: `wdt_two_stage`

## Requirements
- R1: After the asynchronous reset input is deasserted, the arm flag, the power-down bit, the counter, the internal reset and the reset pulse output are all 0.
- R2: While enabled, the counter rises by exactly one for every 2^PRE_W machine-cycle enables. Clocks without a machine-cycle enable change nothing.
- R3: A counter write (wr_addr = 1) made while the arm flag is 0 leaves the counter unchanged.
- R4: A control write (wr_addr = 0) loads the arm flag from wr_data bit 0. A counter write made while the flag is 1 loads wr_data into the counter and clears the flag at the same clock edge.
- R5: Reloading value v causes overflow after exactly (2^CNT_W − v) × 2^PRE_W machine-cycle enables. So v = 0 gives the longest interval and all-ones gives the shortest. A later control write that clears the arm flag does not stop the watchdog.
- R6: An overflow raises wdt_rst for exactly one clock. It also raises rst_out for exactly PULSE_LEN machine-cycle enables, and an overflow that occurs while rst_out is high does not extend the pulse.
- R7: While ew_n is high, the counter reads 0 and the block produces no reset, whatever the writes and enables. Under the same condition the power-down bit (control wr_data bit 1) can be written.
- R8: While ew_n is low, the power-down bit reads 0, and a control write that tries to set it has no effect.
- R9: An accepted reload also clears the prescaler, so the next counter step comes a full 2^PRE_W enables later.
- R10: An overflow clears the arm flag, the prescaler and the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| mc_en | input | 1 | One-clock machine-cycle enable |
| ew_n | input | 1 | Watchdog enable pin, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register select: 0 control, 1 counter |
| wr_data | input | CNT_W | Write data: counter value, or control bit 0 = arm and bit 1 = power-down |
| arm_q | output | 1 | Arm (load-enable) flag |
| pd_q | output | 1 | Power-down request bit |
| cnt_q | output | CNT_W | Counter value |
| wdt_rst | output | 1 | Internal system reset, one clock |
| rst_out | output | 1 | External reset pulse, PULSE_LEN machine cycles |

## Verification
The bench sweeps every reload value of a 4-bit counter with a 2-bit prescaler and compares the overflow time with the arithmetic interval. A design that forgot to clear the prescaler on reload, or compared against the wrong terminal count, would overflow early or late. It also reloads in the middle of a prescaler period, and it writes the counter without arming first; a design that fed the watchdog on a single write would shift the counter there. The disabled state, the blocked power-down bit, and the length of both reset outputs are measured at the ports, so a pulse that is re-triggered or cut short shows up as a wrong count.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   typedef enum logic {
      WSEL_CTRL  = 1'b0,
      WSEL_COUNT = 1'b1
   } wsel_e;

   localparam int CTRL_ARM_BIT = 0;
   localparam int CTRL_PD_BIT  = 1;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int PRE_W = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr,
   output logic tick
);
   localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};

   if (PRE_W < 1) begin : g_bad_pre
      $error("wdt_prescaler: PRE_W must be at least 1");
   end

   logic [PRE_W-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pre_q <= '0;
      else if (clr)  pre_q <= '0;
      else if (run)  pre_q <= pre_q + 1'b1;
   end

   assign tick = run & ~clr & (pre_q == PRE_MAX);

   // R2: two counter steps never come from adjacent clocks
   p_tick_spaced_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold_clr,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt_q,
   output logic             ovf
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (CNT_W < 2) begin : g_bad_cnt
      $error("wdt_count: CNT_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (hold_clr) cnt_q <= '0;
      else if (load)     cnt_q <= load_val;
      else if (tick)     cnt_q <= cnt_q + 1'b1;
   end

   assign ovf = tick & ~load & ~hold_clr & (cnt_q == CNT_MAX);

   // R2: without a reload the count only holds or steps by one
   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !hold_clr) |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)));
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic ew_n,
   input  logic ovf,
   input  logic ctrl_wr,
   input  logic cnt_wr,
   input  logic arm_d,
   input  logic pd_d,
   output logic arm_q,
   output logic pd_q,
   output logic load
);
   assign load = cnt_wr & arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       arm_q <= 1'b0;
      else if (ovf)     arm_q <= 1'b0;
      else if (load)    arm_q <= 1'b0;
      else if (ctrl_wr) arm_q <= arm_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pd_q <= 1'b0;
      else if (ovf)     pd_q <= 1'b0;
      else if (!ew_n)   pd_q <= 1'b0;
      else if (ctrl_wr) pd_q <= pd_d;
   end

   // R4: an accepted reload consumes the arm flag
   p_arm_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !arm_q);
   // R8: power-down stays blocked while the pin enables the watchdog
   p_pd_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ew_n |=> !pd_q);
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
   parameter int PULSE_LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   input  logic step,
   output logic sys_rst,
   output logic rst_out
);
   localparam int PW = $clog2(PULSE_LEN + 1);

   if (PULSE_LEN < 1) begin : g_bad_len
      $error("wdt_pulse: PULSE_LEN must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sys_rst <= 1'b0;
      else        sys_rst <= trig;
   end

   if (PULSE_LEN == 1) begin : g_single
      logic out_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              out_q <= 1'b0;
         else if (step && out_q)  out_q <= 1'b0;
         else if (trig)           out_q <= 1'b1;
      end
      assign rst_out = out_q;
   end else begin : g_multi
      logic [PW-1:0] left_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     left_q <= '0;
         else if (trig && left_q == '0)  left_q <= PW'(PULSE_LEN);
         else if (step && left_q != '0)  left_q <= left_q - 1'b1;
      end
      assign rst_out = (left_q != '0);
   end

   // R6: internal reset lasts one clock
   p_sysrst_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst |=> !sys_rst);
   // R6: the external pulse only ends on a machine cycle
   p_pulse_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_out && !step) |=> rst_out);
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
   parameter int PRE_W     = 11,
   parameter int CNT_W     = 8,
   parameter int PULSE_LEN = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mc_en,
   input  logic             ew_n,
   input  logic             wr_en,
   input  logic             wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic             arm_q,
   output logic             pd_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic             wdt_rst,
   output logic             rst_out
);
   import wdt_pkg::*;

   logic ctrl_wr, cnt_wr, load, tick, ovf;

   assign ctrl_wr = wr_en & (wr_addr == WSEL_CTRL);
   assign cnt_wr  = wr_en & (wr_addr == WSEL_COUNT);

   wdt_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .ew_n    (ew_n),
      .ovf     (ovf),
      .ctrl_wr (ctrl_wr),
      .cnt_wr  (cnt_wr),
      .arm_d   (wr_data[CTRL_ARM_BIT]),
      .pd_d    (wr_data[CTRL_PD_BIT]),
      .arm_q   (arm_q),
      .pd_q    (pd_q),
      .load    (load)
   );

   wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (mc_en & ~ew_n),
      .clr   (ew_n | load),
      .tick  (tick)
   );

   wdt_count #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold_clr (ew_n),
      .load     (load),
      .load_val (wr_data),
      .tick     (tick),
      .cnt_q    (cnt_q),
      .ovf      (ovf)
   );

   wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig    (ovf),
      .step    (mc_en),
      .sys_rst (wdt_rst),
      .rst_out (rst_out)
   );

   // R7: a high enable pin keeps the counter at zero and blocks reset
   p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ew_n |=> ((cnt_q == '0) && !wdt_rst));
   // R3: an unarmed counter write cannot reload
   p_unarmed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wr && !arm_q && !ew_n && !mc_en) |=> $stable(cnt_q));
endmodule

// File: tb/tb_wdt_two_stage.sv
module tb_wdt_two_stage;
   localparam int PW  = 2;
   localparam int CW  = 4;
   localparam int LEN = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mc_en = 1'b0;
   logic ew_n = 1'b0;
   logic wr_en = 1'b0;
   logic wr_addr = 1'b0;
   logic [CW-1:0] wr_data = '0;
   logic arm_q, pd_q, wdt_rst, rst_out;
   logic [CW-1:0] cnt_q;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   wdt_two_stage #(.PRE_W(PW), .CNT_W(CW), .PULSE_LEN(LEN)) dut (
      .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .ew_n(ew_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .arm_q(arm_q), .pd_q(pd_q), .cnt_q(cnt_q),
      .wdt_rst(wdt_rst), .rst_out(rst_out)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input logic mc, input logic we = 1'b0,
                      input logic a = 1'b0, input logic [CW-1:0] d = '0);
      mc_en = mc; wr_en = we; wr_addr = a; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      mc_en = 1'b0; wr_en = 1'b0;
   endtask

   task automatic mcs(input int n);
      for (int i = 0; i < n; i++) begin
         cyc(1'b0); cyc(1'b0); cyc(1'b1);
      end
   endtask

   task automatic reload(input logic [CW-1:0] v);
      cyc(1'b0, 1'b1, 1'b0, CW'(1));
      cyc(1'b0, 1'b1, 1'b1, v);
   endtask

   // counts machine cycles to overflow, then pulse length
   task automatic measure(output int n, output int plen, output int srst_hi, output int srst_lo);
      n = 0; plen = 0; srst_hi = 0; srst_lo = 0;
      for (int i = 0; i < 2000; i++) begin
         cyc(1'b0); cyc(1'b0); cyc(1'b1);
         n++;
         if (rst_out) break;
      end
      srst_hi = int'(wdt_rst);
      cyc(1'b0);
      srst_lo = int'(wdt_rst);
      plen = 1;
      for (int i = 0; i < 20; i++) begin
         cyc(1'b0); cyc(1'b1);
         if (!rst_out) break;
         plen++;
         cyc(1'b0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int n, plen, sh, sl, seen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 arm", int'(arm_q), 0);
      check("R1 pd", int'(pd_q), 0);
      check("R1 cnt", int'(cnt_q), 0);
      check("R1 rst", int'(wdt_rst) + int'(rst_out), 0);

      // R4 two-step reload
      cyc(1'b0, 1'b1, 1'b0, CW'(1));
      check("R4 arm set", int'(arm_q), 1);
      cyc(1'b0, 1'b1, 1'b1, CW'(2));
      check("R4 load", int'(cnt_q), 2);
      check("R4 arm cleared", int'(arm_q), 0);

      // R2 prescaler ratio and idle clocks
      repeat (10) cyc(1'b0);
      check("R2 idle clocks", int'(cnt_q), 2);
      mcs(4);
      check("R2 four enables", int'(cnt_q), 3);
      mcs(3);
      check("R2 seven enables", int'(cnt_q), 3);
      mcs(1);
      check("R2 eight enables", int'(cnt_q), 4);

      // R3 unarmed write ignored
      cyc(1'b0, 1'b1, 1'b0, CW'(0));
      cyc(1'b0, 1'b1, 1'b1, CW'(9));
      check("R3 unarmed write", int'(cnt_q), 4);

      // R8 power-down blocked while enabled
      cyc(1'b0, 1'b1, 1'b0, CW'(2));
      check("R8 pd blocked", int'(pd_q), 0);

      // R5 / R6 sweep all reload values
      for (int v = 0; v < (1 << CW); v++) begin
         reload(CW'(v));
         measure(n, plen, sh, sl);
         check($sformatf("R5 interval v=%0d", v), n, ((1 << CW) - v) * (1 << PW));
         check($sformatf("R6 pulse v=%0d", v), plen, LEN);
         check($sformatf("R6 wdt_rst high v=%0d", v), sh, 1);
         check($sformatf("R6 wdt_rst low v=%0d", v), sl, 0);
      end

      // R10 overflow clears arm, counter
      reload(CW'(14));
      cyc(1'b0, 1'b1, 1'b0, CW'(1));
      check("R10 armed before", int'(arm_q), 1);
      measure(n, plen, sh, sl);
      check("R10 arm after overflow", int'(arm_q), 0);
      check("R10 interval", n, 2 * (1 << PW));
      reload(CW'(0));
      check("R10 cnt after reload 0", int'(cnt_q), 0);

      // R5 clearing arm does not stop watchdog
      reload(CW'(12));
      cyc(1'b0, 1'b1, 1'b0, CW'(0));
      measure(n, plen, sh, sl);
      check("R5 arm clear no stop", n, 4 * (1 << PW));

      // R9 reload mid prescaler period
      reload(CW'(5));
      mcs(3);
      check("R9 partial period", int'(cnt_q), 5);
      reload(CW'(5));
      measure(n, plen, sh, sl);
      check("R9 full period after reload", n, 11 * (1 << PW));

      // R7 disabled
      ew_n = 1'b1;
      cyc(1'b0);
      check("R7 cnt zero", int'(cnt_q), 0);
      reload(CW'(15));
      seen = 0;
      for (int i = 0; i < 200; i++) begin
         cyc(1'b0); cyc(1'b1);
         if (rst_out || wdt_rst || cnt_q != 0) seen++;
      end
      check("R7 no reset", seen, 0);
      cyc(1'b0, 1'b1, 1'b0, CW'(2));
      check("R7 pd writable", int'(pd_q), 1);
      ew_n = 1'b0;
      cyc(1'b0);
      check("R8 pd forced low", int'(pd_q), 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule